// File: doc/BRIEF.md
# Successive Approximation Register Controller

This block is the digital half of an 8-bit successive-approximation converter. After a start request it runs a binary search over the code space, one bit per clock from the most significant bit down to the least significant bit. Each cycle it presents a trial code to an external DAC. It then reads back a single comparator decision and settles the bit under trial from it.

The controller has two parts. A one-hot shift register, the sequencer, marks the bit under trial. A separate bank of code flip-flops holds the decided bits. Each DAC bit is the OR of its sequencer bit and its code bit, so the bit under trial shows 1 and every other bit shows its stored value. When the last bit is decided, the final code is copied into an output result register and a one-cycle completion pulse is raised. The comparator, the DAC and the sample-and-hold are external.

Top module: `sar_ctrl`

## Requirements
- R1: On a clock edge with `clear_n` low, the sequencer and the code register are emptied. After that edge `busy` = 0, `done` = 0, `dac_code` = 0x00 and `result` = 0x00.
- R2: A clock edge with `start` = 1 and `busy` = 0 begins a conversion. `busy` is high after that edge, and the first trial code is 0x80 (only the MSB set).
- R3: `cmp_hi` = 1 means the DAC level is above the input, and the bit under trial is stored as 0. `cmp_hi` = 0 stores it as 1.
- R4: During a conversion `dac_code` shows the bit under trial as 1, the bits above it as their decided values, and the bits below it as 0. The second trial is therefore 0x40 if the MSB was cleared, or 0xC0 if it was kept.
- R5: The trial position moves exactly one bit toward the LSB per clock. A bit that has been decided does not change again within the same conversion.
- R6: A conversion takes exactly 8 decision edges. `done` is high for the single cycle after the 8th edge that follows the start edge, and `busy` falls on that same edge.
- R7: On the completion edge `result` takes the final 8-bit code. It holds that value until the next completion or clear, and while idle `dac_code` equals `result`.
- R8: A `start` pulse while `busy` = 1 has no effect: the running conversion completes at its original time with its original result.
- R9: `result` is the largest code whose DAC value does not exceed the input. This includes 0x00 for inputs below one step and 0xFF for inputs at or above full scale.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| clear_n | input | 1 | Synchronous active-low clear |
| start | input | 1 | Begin a conversion when idle |
| cmp_hi | input | 1 | Comparator decision, 1 when DAC level exceeds input |
| dac_code | output | 8 | Trial code to the DAC |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 8 | Latched final code |

## Verification
The bench drives inputs and samples outputs on the falling edge, counting falling edges from the start edge. `busy` and the 0x80 trial code are due one edge after start. The second trial code is due one edge later. `done`, the new `result` and the fall of `busy` are all due exactly eight edges after start, and the bench checks `done` low at every earlier sample and high at the eighth. The comparator is modelled combinationally against a half-step input so that every trial is decided in the same cycle it is shown. Late start pulses and a mid-conversion clear are inserted at fixed edge offsets, and their effects are sampled at the next falling edge.

// File: rtl/sar_pkg.sv
// Shared constants for the successive-approximation controller.
// Assumes: nothing beyond standard SystemVerilog.
package sar_pkg;
    localparam int unsigned SAR_WIDTH_DEFAULT = 8;
endpackage

// File: rtl/sar_sequencer.sv
// One-hot trial sequencer: loads a single 1 at the MSB on an accepted start and
// shifts it toward the LSB once per clock until it falls out.
// Assumes: clear_n is synchronous and active low.
module sar_sequencer #(
    parameter int unsigned W = sar_pkg::SAR_WIDTH_DEFAULT
) (
    input  logic         clk,
    input  logic         clear_n,
    input  logic         start,
    output logic [W-1:0] seq_q,
    output logic         busy,
    output logic         load,
    output logic         last
);
    localparam logic [W-1:0] FIRST = {1'b1, {(W-1){1'b0}}};

    // Busy while the marker is inside the register; start accepted only when idle.
    always_comb begin
        busy = |seq_q;
        load = start & ~busy;
        last = seq_q[0];
    end

    // Marker register: clear, load at MSB, or shift one place toward LSB.
    always_ff @(posedge clk) begin
        if (!clear_n)  seq_q <= '0;
        else if (load) seq_q <= FIRST;
        else           seq_q <= seq_q >> 1;
    end

    assert_seq_onehot_R5: assert property (@(posedge clk) disable iff (!clear_n)
        $onehot0(seq_q));
    assert_seq_step_R5: assert property (@(posedge clk) disable iff (!clear_n)
        (busy && clear_n) |=> (seq_q == ($past(seq_q) >> 1)));
    assert_clear_empty_R1: assert property (@(posedge clk)
        !clear_n |=> (seq_q == '0));
endmodule

// File: rtl/sar_code_bank.sv
// Code flip-flops, one per bit. A cell captures the comparator decision only
// while its sequencer bit is set; each DAC bit is the OR of its sequencer and code bits.
// Assumes: seq is one-hot or zero; cmp_hi is stable before the clock edge.
module sar_code_bank #(
    parameter int unsigned W = sar_pkg::SAR_WIDTH_DEFAULT
) (
    input  logic         clk,
    input  logic         clear_n,
    input  logic         load,
    input  logic [W-1:0] seq,
    input  logic         cmp_hi,
    output logic [W-1:0] code_q,
    output logic [W-1:0] code_d,
    output logic [W-1:0] dac_code
);
    for (genvar i = 0; i < W; i++) begin : g_cell
        // Next value: zero on load, decision under trial, else hold.
        always_comb begin
            if (load)        code_d[i] = 1'b0;
            else if (seq[i]) code_d[i] = ~cmp_hi;
            else             code_d[i] = code_q[i];
        end

        // Storage flop with synchronous clear.
        always_ff @(posedge clk) begin
            if (!clear_n) code_q[i] <= 1'b0;
            else          code_q[i] <= code_d[i];
        end

        // DAC drive: NAND of the two complements.
        always_comb dac_code[i] = ~(~seq[i] & ~code_q[i]);

        assert_decision_R3: assert property (@(posedge clk) disable iff (!clear_n)
            (seq[i] && !load) |=> (code_q[i] == !$past(cmp_hi)));
        assert_decided_hold_R5: assert property (@(posedge clk) disable iff (!clear_n)
            (!seq[i] && !load && clear_n) |=> $stable(code_q[i]));
    end
endmodule

// File: rtl/sar_result_reg.sv
// Output result register and completion pulse: captures the final code on the
// edge where the LSB is decided.
// Assumes: code_d already holds the LSB decision on that edge.
module sar_result_reg #(
    parameter int unsigned W = sar_pkg::SAR_WIDTH_DEFAULT
) (
    input  logic         clk,
    input  logic         clear_n,
    input  logic         last,
    input  logic [W-1:0] code_d,
    output logic [W-1:0] result,
    output logic         done
);
    // Latch the final code and raise done for one cycle.
    always_ff @(posedge clk) begin
        if (!clear_n) begin
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= last;
            if (last) result <= code_d;
        end
    end

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!clear_n)
        done |=> !done);
    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!clear_n)
        (!last && clear_n) |=> $stable(result));
endmodule

// File: rtl/sar_ctrl.sv
// Successive-approximation controller top: sequencer, code bank and result register.
// Assumes: external comparator answers combinationally on dac_code within the cycle.
module sar_ctrl #(
    parameter int unsigned W = sar_pkg::SAR_WIDTH_DEFAULT
) (
    input  logic         clk,
    input  logic         clear_n,
    input  logic         start,
    input  logic         cmp_hi,
    output logic [W-1:0] dac_code,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result
);
    localparam logic [W-1:0] FIRST = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] seq_q;
    logic [W-1:0] code_q;
    logic [W-1:0] code_d;
    logic         load;
    logic         last;

    sar_sequencer #(.W(W)) seq_i (
        .clk(clk), .clear_n(clear_n), .start(start),
        .seq_q(seq_q), .busy(busy), .load(load), .last(last)
    );

    sar_code_bank #(.W(W)) code_i (
        .clk(clk), .clear_n(clear_n), .load(load), .seq(seq_q), .cmp_hi(cmp_hi),
        .code_q(code_q), .code_d(code_d), .dac_code(dac_code)
    );

    sar_result_reg #(.W(W)) res_i (
        .clk(clk), .clear_n(clear_n), .last(last), .code_d(code_d),
        .result(result), .done(done)
    );

    assert_first_trial_R2: assert property (@(posedge clk) disable iff (!clear_n)
        (start && !busy && clear_n) |=> (busy && dac_code == FIRST));
    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!clear_n)
        done |-> !busy);
    assert_idle_shows_result_R7: assert property (@(posedge clk) disable iff (!clear_n)
        done |-> (dac_code == result));
endmodule

// File: tb/sar_ctrl_tb.sv
// Self-checking bench: ideal comparator on a half-step input, full sweep.
module sar_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int WATCHDOG_CYCLES = 150000;

    logic         clk = 1'b0;
    logic         clear_n = 1'b0;
    logic         start = 1'b0;
    logic         cmp_hi;
    logic [W-1:0] dac_code;
    logic         busy;
    logic         done;
    logic [W-1:0] result;
    logic [9:0]   vin2 = '0;   // input in half-step units

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Ideal comparator: DAC level above input.
    assign cmp_hi = ({1'b0, dac_code, 1'b0} > vin2);

    sar_ctrl #(.W(W)) dut_i (
        .clk(clk), .clear_n(clear_n), .start(start), .cmp_hi(cmp_hi),
        .dac_code(dac_code), .busy(busy), .done(done), .result(result)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s vin2=%0d actual=%0h expected=%0h", req, vin2, act, exp);
        end
    endtask

    // Run one conversion; late_start inserts a start pulse at that edge offset (0 = none).
    task automatic convert(input int v2, input int late_start);
        int exp_code;
        exp_code = (v2 / 2 > 255) ? 255 : v2 / 2;
        vin2 = v2[9:0];
        start = 1'b1;
        @(negedge clk);               // start edge passed
        start = 1'b0;
        check(busy == 1'b1, "R2", busy, 1);
        check(dac_code == 8'h80, "R2", dac_code, 8'h80);
        for (int k = 1; k <= 8; k++) begin
            if (k == 2) check(dac_code == ((v2 >= 256) ? 8'hC0 : 8'h40), "R4", dac_code,
                              (v2 >= 256) ? 8'hC0 : 8'h40);
            if (k == late_start) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            if (k < 8) check(done == 1'b0 && busy == 1'b1, "R6", {busy, done}, 2);
        end
        check(done == 1'b1 && busy == 1'b0, "R6", {busy, done}, 1);
        check(result == exp_code[7:0], (late_start != 0) ? "R8" : "R9", result, exp_code);
        check(dac_code == result, "R7", dac_code, result);
        @(negedge clk);
        check(done == 1'b0, "R6", done, 0);
    endtask

    initial begin : main
        int prev;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        check(busy == 0 && done == 0, "R1", {busy, done}, 0);
        check(dac_code == 0 && result == 0, "R1", {dac_code, result}, 0);
        clear_n = 1'b1;
        @(negedge clk);

        // R9 / R3 / R4: sweep every half-step level plus over-range
        for (int v = 0; v < 512; v++) convert(v, 0);
        convert(520, 0);

        // R7: result holds while idle
        prev = result;
        repeat (5) @(negedge clk);
        check(result == prev[7:0], "R7", result, prev);

        // R8: start while busy ignored, at several offsets
        convert(123, 3);
        convert(400, 1);
        convert(7, 7);

        // R1: clear in the middle of a conversion
        vin2 = 10'd300;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        clear_n = 1'b0;
        @(negedge clk);
        check(busy == 0 && done == 0, "R1", {busy, done}, 0);
        check(dac_code == 0 && result == 0, "R1", {dac_code, result}, 0);
        clear_n = 1'b1;
        @(negedge clk);
        convert(301, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule